// File: doc/BRIEF.md
# Shader Control-Flow Sequencer

This block is the program-counter unit of a small vertex-shader core. It presents a fetch address to an external program memory, receives the 32-bit instruction word in the same cycle, and handles the flow-control opcodes: counted loops, conditional blocks, subroutine calls, jumps and the end marker. Every other opcode is treated as a one-cycle no-op that advances the PC by one. The arithmetic datapath is not part of this block.

Three return stacks of fixed depth hold the loop, conditional-block and call contexts. After each instruction the incremented PC is compared in a fixed order: first with the end of the innermost loop, then with the end of the innermost conditional block, then with the end of the innermost call. Conditions come from a 16-bit boolean uniform, or from two compare flags tested against reference bits in the instruction. Loops take their trip count, starting counter value and step from one of four integer uniforms.

A start pulse loads the PC from the entry-point input and clears the done flag. The END opcode raises done and freezes the PC until the next start pulse.

Top module: `shader_flow_seq`

## Requirements
- R1: After reset, done is 1, pc is 0, loop_ctr is 0 and overflow is 0.
- R2: A start pulse loads pc from entry_pc at the next edge, clears done and empties all three stacks. While running, any opcode outside the flow-control set advances pc by one per cycle.
- R3: Encoding. The opcode is instr[31:26]: END 0x22, CALL 0x24, CALLC 0x25, CALLU 0x26, IFU 0x27, IFC 0x28, LOOP 0x29, JMPC 0x2C, JMPU 0x2D, and opcode 0x00 is a no-op. The target is instr[21:10] and the block length is instr[9:0]. The boolean selector is instr[25:22]. The x reference is instr[25], the y reference is instr[24], and the condition mode is instr[23:22].
- R4: END sets done at the next edge, and pc stays at the address of the END instruction.
- R5: While done is 1 and start is 0, pc and loop_ctr do not change.
- R6: JMPU jumps to the target when bool_uni[sel] differs from instr[0]. Otherwise execution continues at pc+1.
- R7: JMPC jumps when its condition is true. Let mx = (cmp_x == x reference) and my = (cmp_y == y reference). Mode 0 tests mx|my, mode 1 tests mx&my, mode 2 tests mx and mode 3 tests my.
- R8: A true IFU or IFC pushes end = target and resume = target+length, then continues at pc+1. When execution reaches the end address, pc goes to the resume address. A false condition sends pc straight to the target. IFU tests bool_uni[sel] and IFC uses the R7 condition.
- R9: CALL always calls. CALLU calls when bool_uni[sel] is 1, and CALLC calls when the R7 condition is true. A call jumps to the target and records end = target+length and return = pc+1. A call that is not taken continues at pc+1.
- R10: LOOP uses integer uniform k = instr[23:22], a 24-bit group at int_uni[24k+23:24k]. Byte 0 plus one is the trip count, byte 1 is loaded into loop_ctr and byte 2 is the step. The body runs from pc+1 through the target instruction, inclusive. At each pass end, loop_ctr is increased by the step.
- R11: The post-instruction PC is tested against the loop end first, then the if end using the PC that results, then the call end.
- R12: A push onto a full stack is dropped and sets overflow, which stays at 1 until reset. The loop stack is 4 deep, the if stack 8 deep and the call stack 4 deep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin execution at entry_pc |
| entry_pc | input | 12 | Entry-point address |
| instr | input | 32 | Instruction word fetched at pc |
| bool_uni | input | 16 | Boolean uniform bits |
| int_uni | input | 96 | Four integer uniforms of three bytes each |
| cmp_x | input | 1 | Compare flag x |
| cmp_y | input | 1 | Compare flag y |
| pc | output | 12 | Current fetch address |
| loop_ctr | output | 8 | Loop counter |
| done | output | 1 | Program finished or idle |
| overflow | output | 1 | Sticky stack overflow |

## Verification
Each instruction takes exactly one clock. Its effect on pc, loop_ctr and the stacks appears after the edge that executes it, and done rises one edge after the END instruction executes. The bench drives start at a falling edge and samples at every falling edge after that. It counts how many instructions run before done goes high, so each test checks both the path taken (the final pc and the instruction count) and the loop arithmetic (the final loop_ctr), with expected values worked out from the program layout.

// File: rtl/shader_flow_seq.sv
module shader_flow_seq #(
  parameter int PC_W       = 12,
  parameter int LOOP_DEPTH = 4,
  parameter int IF_DEPTH   = 8,
  parameter int CALL_DEPTH = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [PC_W-1:0] entry_pc,
  input  logic [31:0]     instr,
  input  logic [15:0]     bool_uni,
  input  logic [95:0]     int_uni,
  input  logic            cmp_x,
  input  logic            cmp_y,
  output logic [PC_W-1:0] pc,
  output logic [7:0]      loop_ctr,
  output logic            done,
  output logic            overflow
);
  localparam int LSW = $clog2(LOOP_DEPTH + 1);
  localparam int ISW = $clog2(IF_DEPTH + 1);
  localparam int CSW = $clog2(CALL_DEPTH + 1);
  localparam int LIX = $clog2(LOOP_DEPTH);
  localparam int IIX = $clog2(IF_DEPTH);
  localparam int CIX = $clog2(CALL_DEPTH);

  localparam logic [5:0] OP_END = 6'h22, OP_CALL = 6'h24, OP_CALLC = 6'h25,
                         OP_CALLU = 6'h26, OP_IFU = 6'h27, OP_IFC = 6'h28,
                         OP_LOOP = 6'h29, OP_JMPC = 6'h2C, OP_JMPU = 6'h2D;

  wire [5:0]      op   = instr[31:26];
  wire [PC_W-1:0] tgt  = instr[10 +: PC_W];
  wire [PC_W-1:0] blen = PC_W'(instr[9:0]);
  wire            bval = bool_uni[instr[25:22]];
  wire [23:0]     iu   = int_uni[24*instr[23:22] +: 24];
  wire            run  = ~done;
  wire            act  = run & (op != OP_END);
  wire [PC_W-1:0] seq  = pc + 1'b1;

  logic cond;
  wire mx = (cmp_x == instr[25]);
  wire my = (cmp_y == instr[24]);
  always_comb begin
    case (instr[23:22])
      2'd0:    cond = mx | my;
      2'd1:    cond = mx & my;
      2'd2:    cond = mx;
      default: cond = my;
    endcase
  end

  wire jump    = (op == OP_JMPC & cond) | (op == OP_JMPU & (bval != instr[0]));
  wire do_call = (op == OP_CALL) | (op == OP_CALLC & cond) | (op == OP_CALLU & bval);
  wire if_op   = (op == OP_IFU) | (op == OP_IFC);
  wire if_true = (op == OP_IFU) ? bval : cond;
  wire [PC_W-1:0] c0 = (jump | do_call | (if_op & ~if_true)) ? tgt : seq;

  // loop stack
  logic [LSW-1:0]  lsp;
  logic [PC_W-1:0] l_start [LOOP_DEPTH];
  logic [PC_W-1:0] l_end   [LOOP_DEPTH];
  logic [8:0]      l_it    [LOOP_DEPTH];
  logic [7:0]      l_inc   [LOOP_DEPTH];
  wire [LIX-1:0] l_wr = LIX'(lsp);
  wire [LIX-1:0] l_rd = LIX'(lsp - 1'b1);
  wire l_req  = act & (op == OP_LOOP);
  wire l_full = (lsp == LSW'(LOOP_DEPTH));
  wire l_push = l_req & ~l_full;
  wire [PC_W-1:0] l_start_t = l_push ? seq : l_start[l_rd];
  wire [PC_W-1:0] l_end_t   = l_push ? tgt + 1'b1 : l_end[l_rd];
  wire [8:0]      l_it_t    = l_push ? {1'b0, iu[7:0]} + 9'd1 : l_it[l_rd];
  wire [7:0]      l_inc_t   = l_push ? iu[23:16] : l_inc[l_rd];
  wire l_hit = act & (l_push | lsp != '0) & (c0 == l_end_t);
  wire [8:0] l_dec = l_it_t - 9'd1;
  wire l_pop = l_hit & (l_dec == '0);
  wire [PC_W-1:0] c1 = (l_hit & ~l_pop) ? l_start_t : c0;
  wire [7:0] lc_base = l_push ? iu[15:8] : loop_ctr;
  wire [7:0] lc_next = lc_base + (l_hit ? l_inc_t : 8'd0);

  // if stack
  logic [ISW-1:0]  isp;
  logic [PC_W-1:0] i_end [IF_DEPTH];
  logic [PC_W-1:0] i_res [IF_DEPTH];
  wire [IIX-1:0] i_wr = IIX'(isp);
  wire [IIX-1:0] i_rd = IIX'(isp - 1'b1);
  wire i_req  = act & if_op & if_true;
  wire i_full = (isp == ISW'(IF_DEPTH));
  wire i_push = i_req & ~i_full;
  wire [PC_W-1:0] i_end_t = i_push ? tgt : i_end[i_rd];
  wire [PC_W-1:0] i_res_t = i_push ? tgt + blen : i_res[i_rd];
  wire i_hit = act & (i_push | isp != '0) & (c1 == i_end_t);
  wire [PC_W-1:0] c2 = i_hit ? i_res_t : c1;

  // call stack
  logic [CSW-1:0]  csp;
  logic [PC_W-1:0] c_end [CALL_DEPTH];
  logic [PC_W-1:0] c_ret [CALL_DEPTH];
  wire [CIX-1:0] c_wr = CIX'(csp);
  wire [CIX-1:0] c_rd = CIX'(csp - 1'b1);
  wire c_req  = act & do_call;
  wire c_full = (csp == CSW'(CALL_DEPTH));
  wire c_push = c_req & ~c_full;
  wire [PC_W-1:0] c_end_t = c_push ? tgt + blen : c_end[c_rd];
  wire [PC_W-1:0] c_ret_t = c_push ? seq : c_ret[c_rd];
  wire c_hit = act & (c_push | csp != '0) & (c2 == c_end_t);
  wire [PC_W-1:0] c3 = c_hit ? c_ret_t : c2;

  wire ovf_ev = (l_req & l_full) | (i_req & i_full) | (c_req & c_full);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc       <= '0;
      done     <= 1'b1;
      loop_ctr <= '0;
      overflow <= 1'b0;
      lsp      <= '0;
      isp      <= '0;
      csp      <= '0;
    end else if (start) begin
      pc   <= entry_pc;
      done <= 1'b0;
      lsp  <= '0;
      isp  <= '0;
      csp  <= '0;
    end else if (run) begin
      pc       <= act ? c3 : pc;
      done     <= ~act;
      loop_ctr <= lc_next;
      overflow <= overflow | ovf_ev;
      lsp      <= lsp + LSW'(l_push) - LSW'(l_pop);
      isp      <= isp + ISW'(i_push) - ISW'(i_hit);
      csp      <= csp + CSW'(c_push) - CSW'(c_hit);
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n && !start) begin
      if (l_push) begin
        l_start[l_wr] <= l_start_t;
        l_end[l_wr]   <= l_end_t;
        l_inc[l_wr]   <= l_inc_t;
        l_it[l_wr]    <= l_hit ? l_dec : l_it_t;
      end else if (l_hit && !l_pop) begin
        l_it[l_rd] <= l_dec;
      end
      if (i_push) begin
        i_end[i_wr] <= i_end_t;
        i_res[i_wr] <= i_res_t;
      end
      if (c_push) begin
        c_end[c_wr] <= c_end_t;
        c_ret[c_wr] <= c_ret_t;
      end
    end
  end
endmodule

// File: rtl/shader_flow_seq_chk.sv
module shader_flow_seq_chk #(
  parameter int PC_W = 12, parameter int LOOP_DEPTH = 4,
  parameter int IF_DEPTH = 8, parameter int CALL_DEPTH = 4,
  parameter int LSW = 3, parameter int ISW = 4, parameter int CSW = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic [PC_W-1:0] entry_pc,
  input logic [31:0]     instr,
  input logic [PC_W-1:0] pc,
  input logic [7:0]      loop_ctr,
  input logic            done,
  input logic            overflow,
  input logic [LSW-1:0]  lsp,
  input logic [ISW-1:0]  isp,
  input logic [CSW-1:0]  csp
);
  // R2
  start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (!done && pc == $past(entry_pc)));
  // R4
  end_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!done && !start && instr[31:26] == 6'h22) |=> (done && pc == $past(pc)));
  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(pc) && $stable(loop_ctr)));
  // R12
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);
  // R12
  depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(lsp) <= LOOP_DEPTH) && (32'(isp) <= IF_DEPTH) && (32'(csp) <= CALL_DEPTH));
endmodule

bind shader_flow_seq shader_flow_seq_chk #(
  .PC_W(PC_W), .LOOP_DEPTH(LOOP_DEPTH), .IF_DEPTH(IF_DEPTH), .CALL_DEPTH(CALL_DEPTH),
  .LSW(LSW), .ISW(ISW), .CSW(CSW)
) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .entry_pc(entry_pc), .instr(instr),
  .pc(pc), .loop_ctr(loop_ctr), .done(done), .overflow(overflow),
  .lsp(lsp), .isp(isp), .csp(csp)
);

// File: tb/shader_flow_seq_tb.sv
module shader_flow_seq_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, cmp_x = 1'b0, cmp_y = 1'b0;
  logic [11:0] entry_pc = '0;
  logic [15:0] bool_uni = 16'hA5C3;
  logic [95:0] int_uni = '0;
  logic [11:0] pc;
  logic [7:0]  loop_ctr;
  logic        done, overflow;
  logic [31:0] prog [0:255];
  wire  [31:0] instr = prog[pc[7:0]];
  int tests = 0, fails = 0, cycles = 0;

  always #2 clk = ~clk;

  shader_flow_seq dut_i (.clk(clk), .rst_n(rst_n), .start(start), .entry_pc(entry_pc),
    .instr(instr), .bool_uni(bool_uni), .int_uni(int_uni), .cmp_x(cmp_x), .cmp_y(cmp_y),
    .pc(pc), .loop_ctr(loop_ctr), .done(done), .overflow(overflow));

  localparam logic [5:0] END = 6'h22, CALL = 6'h24, CALLC = 6'h25, CALLU = 6'h26,
    IFU = 6'h27, IFC = 6'h28, LOOP = 6'h29, JMPC = 6'h2C, JMPU = 6'h2D;

  function automatic logic [31:0] enc(input logic [5:0] op, input logic [3:0] hi,
                                      input logic [11:0] t, input logic [9:0] n);
    return {op, hi, t, n};
  endfunction

  function automatic bit condf(input int m, input bit cx, input bit cy, input bit rx, input bit ry);
    bit a = (cx == rx), b = (cy == ry);
    case (m)
      0: return a | b;
      1: return a & b;
      2: return a;
      default: return b;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear();
    for (int i = 0; i < 256; i++) prog[i] = 32'h0;
  endtask

  task automatic go(input logic [11:0] ep, output int n);
    @(negedge clk); start = 1'b1; entry_pc = ep;
    @(negedge clk); start = 1'b0; n = 0;
    while (!done && n < 2000) begin @(negedge clk); n++; end
  endtask

  initial begin
    forever begin
      @(posedge clk); cycles++;
      if (cycles > 150000) begin
        fails++; tests++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    end
  end

  initial begin
    int n;
    clear();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(done == 1 && pc == 0 && loop_ctr == 0 && overflow == 0, "R1 reset", int'(pc), 0);

    // R2 R4: straight run from entry 2 to END at 6
    prog[6] = enc(END, 0, 0, 0);
    go(12'd2, n);
    chk(n == 5, "R2 sequential count", n, 5);
    chk(pc == 6, "R4 END pc", int'(pc), 6);
    // R5
    repeat (4) @(negedge clk);
    chk(done && pc == 6, "R5 idle hold", int'(pc), 6);

    // R6 JMPU sweep (R3 fields)
    for (int s = 0; s < 16; s++)
      for (int v = 0; v < 2; v++) begin
        clear();
        prog[0] = enc(JMPU, 4'(s), 12'd10, 10'(v));
        prog[1] = enc(END, 0, 0, 0);
        prog[10] = enc(END, 0, 0, 0);
        go(12'd0, n);
        chk(pc == ((bool_uni[s] != v) ? 10 : 1), "R6 JMPU", int'(pc), (bool_uni[s] != v) ? 10 : 1);
      end

    // R7 JMPC sweep
    for (int k = 0; k < 64; k++) begin
      bit e;
      clear();
      cmp_x = k[0]; cmp_y = k[1];
      prog[0] = enc(JMPC, {k[2], k[3], 2'(k >> 4)}, 12'd20, 0);
      prog[1] = enc(END, 0, 0, 0);
      prog[20] = enc(END, 0, 0, 0);
      go(12'd0, n);
      e = condf(k >> 4, k[0], k[1], k[2], k[3]);
      chk(pc == (e ? 20 : 1), "R7 JMPC", int'(pc), e ? 20 : 1);
    end

    // R8 IFU and IFC: then-block 1..2, else-block at 3, END at 4
    for (int k = 0; k < 80; k++) begin
      bit e;
      clear();
      if (k < 16) begin
        prog[0] = enc(IFU, 4'(k), 12'd3, 10'd1);
        e = bool_uni[k];
      end else begin
        cmp_x = k[0]; cmp_y = k[1];
        prog[0] = enc(IFC, {k[2], k[3], 2'((k - 16) >> 4)}, 12'd3, 10'd1);
        e = condf((k - 16) >> 4, k[0], k[1], k[2], k[3]);
      end
      prog[4] = enc(END, 0, 0, 0);
      go(12'd0, n);
      chk(n == (e ? 4 : 3) && pc == 4, "R8 if block", n, e ? 4 : 3);
    end

    // R9 CALL, CALLU, CALLC: body 10..11, return to END at 1
    for (int k = 0; k < 81; k++) begin
      bit e;
      clear();
      if (k == 0) begin
        prog[0] = enc(CALL, 0, 12'd10, 10'd2); e = 1;
      end else if (k < 17) begin
        prog[0] = enc(CALLU, 4'(k - 1), 12'd10, 10'd2); e = bool_uni[k - 1];
      end else begin
        cmp_x = k[0]; cmp_y = k[1];
        prog[0] = enc(CALLC, {k[2], k[3], 2'((k - 17) >> 4)}, 12'd10, 10'd2);
        e = condf((k - 17) >> 4, k[0], k[1], k[2], k[3]);
      end
      prog[1] = enc(END, 0, 0, 0);
      go(12'd0, n);
      chk(n == (e ? 4 : 2) && pc == 1, "R9 call", n, e ? 4 : 2);
    end

    // R10 LOOP sweep over uniform select and trip count
    for (int s = 0; s < 4; s++)
      for (int t = 0; t < 3; t++) begin
        int trips, b0, b1, b2;
        b0 = t * 3; b1 = 40 + s * 50; b2 = 7 + s * 30;
        trips = b0 + 1;
        clear();
        int_uni = '0;
        int_uni[24*s +: 24] = {8'(b2), 8'(b1), 8'(b0)};
        prog[0] = enc(LOOP, {2'b00, 2'(s)}, 12'd2, 0);
        prog[3] = enc(END, 0, 0, 0);
        go(12'd0, n);
        chk(n == 2 + 2 * trips, "R10 loop passes", n, 2 + 2 * trips);
        chk(loop_ctr == 8'(b1 + trips * b2), "R10 loop counter", int'(loop_ctr), (b1 + trips * b2) % 256);
      end

    // R11 loop end shared with call end: loop unwinds before the call returns
    clear();
    int_uni = '0;
    int_uni[23:0] = {8'd3, 8'd5, 8'd1};
    prog[0] = enc(CALL, 0, 12'd10, 10'd2);
    prog[1] = enc(END, 0, 0, 0);
    prog[10] = enc(LOOP, 0, 12'd11, 0);
    go(12'd0, n);
    chk(n == 5 && pc == 1, "R11 priority count", n, 5);
    chk(loop_ctr == 11, "R11 priority counter", int'(loop_ctr), 11);

    // R12 if stack exactly full, then one more
    bool_uni = 16'hFFFF;
    clear();
    for (int i = 0; i < 8; i++) prog[i] = enc(IFU, 0, 12'd100, 0);
    prog[8] = enc(END, 0, 0, 0);
    go(12'd0, n);
    chk(overflow == 0, "R12 full no flag", int'(overflow), 0);
    prog[8] = enc(IFU, 0, 12'd100, 0);
    prog[9] = enc(END, 0, 0, 0);
    go(12'd0, n);
    chk(overflow == 1 && pc == 9, "R12 overflow set", int'(overflow), 1);
    clear();
    prog[0] = enc(END, 0, 0, 0);
    go(12'd0, n);
    chk(overflow == 1, "R12 overflow sticky", int'(overflow), 1);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule